// File: doc/BRIEF.md
# Cache RAM debug read controller

This block gives privileged software a way to look at the raw contents of a core's internal arrays: instruction-side tag, data, branch-target, history, TLB and indirect-predictor stores, data-side tag, data and two TLBs, and the level 2 tag, data, snoop tag, ECC, dirty and TLB stores. Software writes one 32-bit index word. The block splits that word into a RAM identifier, a way and an index. It reads one entry of the selected array and packs it into four 32-bit result words, presented together on a 128-bit result bus. Word positions that the chosen array does not use are cleared.

The read is sequenced by a three-state machine. IDLE waits for a write. An accepted, well-formed write (IDLE to FETCH) captures the fields and the caller's attributes. FETCH issues the array read and always moves on to COMMIT. COMMIT packs the entry, applies the security and ownership filter, loads the result words and always returns to IDLE. A write that fails the privilege check, or that names an unknown identifier, keeps the machine in IDLE and sets a sticky error flag. The arrays are modelled inside the block and are loaded through a fill port, which stands in for the cache pipelines' write side.

Top module: `ramdbg_reader`

## Requirements
- R1: The index word carries the RAM identifier in bits 31:24, the way in bits 21:18 and the index in bits 17:0. The entry read is addressed by {way bit 0, index bits 1:0} at the default parameters, and the fill port forms its address the same way. Bits 23:22 and all other way and index bits have no effect on which entry is read.
- R2: Identifier codes and the count of low bits kept in result words 0,1,2,3 are: 0x00 32,0,0,0; 0x01 32,32,8,0; 0x02 32,32,14,0; 0x03 32,16,0,0; 0x04 32,32,32,0; 0x05 32,0,0,0; 0x08 29,7,0,0; 0x09 32,32,7,7; 0x0A and 0x0B 32,32,32,6; 0x10 30,7,0,0; 0x11 32,32,32,32; 0x12 29,7,0,0; 0x13 16,0,0,0; 0x14 18,0,0,0; 0x18 32,32,32,4. Result word k is bits 32k+31:32k of the 128-bit bus, and it takes the same bits of the stored entry with the unkept bits cleared.
- R3: For a write accepted at clock edge N, `result` changes and `done` is high for exactly one cycle after edge N+2.
- R4: `busy` is high after the accepting edge until the edge that raises `done`. A write presented while `busy` is high is not accepted and produces no result.
- R5: A write with privilege level 0 (`wr_priv` = 0) starts no read, leaves `result` unchanged, produces no `done`, and sets `err`.
- R6: A write whose identifier is not listed in R2 starts no read, leaves `result` unchanged, produces no `done`, and sets `err`.
- R7: `err` stays high once set, including across later accepted reads, and only reset clears it.
- R8: A secure caller (`wr_ns` = 0) receives the packed entry whatever the entry's valid and non-secure flags are.
- R9: A non-secure caller (`wr_ns` = 1) receives the packed entry only when the entry is valid and marked non-secure. Otherwise all four result words are zero.
- R10: Identifiers 0x00 to 0x0B and 0x18 are private. A read from a requester with `wr_core` different from `own_core` returns all zeros. Identifiers 0x10, 0x11, 0x13 and 0x14 are shared and return their contents to any requester.
- R11: For identifier 0x12, index bits 17:16 name the core whose copy is read. The read returns all zeros unless that field equals `wr_core`.
- R12: After reset, `busy`, `done` and `err` are low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Index word write strobe |
| wr_data | input | 32 | Index word |
| wr_priv | input | 2 | Privilege level of the writer |
| wr_ns | input | 1 | Writer is in the non-secure state |
| wr_core | input | 2 | Core number of the writer |
| own_core | input | 2 | Core number that owns the private arrays |
| fill_en | input | 1 | Array load strobe |
| fill_ram_id | input | 8 | Identifier of the array to load |
| fill_way | input | 4 | Way of the entry to load |
| fill_index | input | 18 | Index of the entry to load |
| fill_valid | input | 1 | Valid flag stored with the entry |
| fill_ns | input | 1 | Non-secure flag stored with the entry |
| fill_data | input | 128 | Entry contents |
| busy | output | 1 | A read is in progress |
| done | output | 1 | One-cycle pulse when result is loaded |
| err | output | 1 | Sticky rejected-write flag |
| result | output | 128 | Four packed 32-bit result words |

## Verification
The hardest case to reach is a write that arrives while a read is still in flight. The second write must vanish without a trace. To set this up, the stimulus holds `wr_en` high, with a different index word, through the cycle just after an accepted write. It confirms that `busy` is high at that moment. The scoreboard then rejects any extra `done` pulse, and it checks that the single result belongs to the first word. The filter paths need entries whose valid and non-secure flags disagree. These entries are loaded through the fill port and then read by secure and non-secure callers, by the owning core and by a foreign core, and by snoop-tag reads whose index bits 17:16 match or miss the requester.

// File: rtl/ramdbg_pkg.sv
package ramdbg_pkg;

    localparam int WORD_W = 32;
    localparam int NWORDS = 4;
    localparam int RAW_W  = WORD_W * NWORDS;
    localparam int SLOT_W = 4;
    localparam int SLOTS  = 1 << SLOT_W;
    localparam int WID_W  = 6;

    typedef enum logic [1:0] {
        GRP_ISIDE,
        GRP_DSIDE,
        GRP_L2_SHARED,
        GRP_L2_PRIVATE
    } grp_e;

    typedef struct packed {
        logic              known;
        logic [SLOT_W-1:0] slot;
        grp_e              grp;
        logic              snoop;
    } ramsel_t;

    // Kept low bits per result word, packed {w3, w2, w1, w0}.
    function automatic logic [NWORDS*WID_W-1:0] word_widths(input logic [SLOT_W-1:0] slot);
        logic [NWORDS*WID_W-1:0] w;
        unique case (slot)
            4'd0:    w = {6'd0,  6'd0,  6'd0,  6'd32};
            4'd1:    w = {6'd0,  6'd8,  6'd32, 6'd32};
            4'd2:    w = {6'd0,  6'd14, 6'd32, 6'd32};
            4'd3:    w = {6'd0,  6'd0,  6'd16, 6'd32};
            4'd4:    w = {6'd0,  6'd32, 6'd32, 6'd32};
            4'd5:    w = {6'd0,  6'd0,  6'd0,  6'd32};
            4'd6:    w = {6'd0,  6'd0,  6'd7,  6'd29};
            4'd7:    w = {6'd7,  6'd7,  6'd32, 6'd32};
            4'd8:    w = {6'd6,  6'd32, 6'd32, 6'd32};
            4'd9:    w = {6'd6,  6'd32, 6'd32, 6'd32};
            4'd10:   w = {6'd0,  6'd0,  6'd7,  6'd30};
            4'd11:   w = {6'd32, 6'd32, 6'd32, 6'd32};
            4'd12:   w = {6'd0,  6'd0,  6'd7,  6'd29};
            4'd13:   w = {6'd0,  6'd0,  6'd0,  6'd16};
            4'd14:   w = {6'd0,  6'd0,  6'd0,  6'd18};
            default: w = {6'd4,  6'd32, 6'd32, 6'd32};
        endcase
        return w;
    endfunction

endpackage

// File: rtl/ramdbg_decode.sv
module ramdbg_decode
    import ramdbg_pkg::*;
(
    input  logic [7:0] ram_id,
    output ramsel_t    sel
);

    always_comb begin
        sel       = '0;
        sel.known = 1'b1;
        sel.grp   = GRP_ISIDE;
        if (ram_id <= 8'h05) begin
            sel.slot = ram_id[3:0];
        end else if (ram_id >= 8'h08 && ram_id <= 8'h0B) begin
            sel.slot = ram_id[3:0] - 4'd2;
            sel.grp  = GRP_DSIDE;
        end else if (ram_id >= 8'h10 && ram_id <= 8'h14) begin
            sel.slot  = ram_id[3:0] + 4'd10;
            sel.snoop = (ram_id == 8'h12);
            sel.grp   = (ram_id == 8'h12) ? GRP_L2_PRIVATE : GRP_L2_SHARED;
        end else if (ram_id == 8'h18) begin
            sel.slot = 4'd15;
            sel.grp  = GRP_L2_PRIVATE;
        end else begin
            sel.known = 1'b0;
        end
    end

endmodule

// File: rtl/ramdbg_array.sv
module ramdbg_array
    import ramdbg_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_valid,
    input  logic              wr_ns,
    input  logic [RAW_W-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [SLOT_W-1:0] rd_slot,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic              rd_ns,
    output logic [RAW_W-1:0]  rd_data
);

    localparam int ROWS = 1 << (SLOT_W + ADDR_W);

    logic [RAW_W+1:0] mem [ROWS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[{wr_slot, wr_addr}] <= {wr_valid, wr_ns, wr_data};
        end
        if (rd_en) begin
            {rd_valid, rd_ns, rd_data} <= mem[{rd_slot, rd_addr}];
        end
    end

endmodule

// File: rtl/ramdbg_pack.sv
module ramdbg_pack
    import ramdbg_pkg::*;
(
    input  logic [SLOT_W-1:0] slot,
    input  logic              blank,
    input  logic [RAW_W-1:0]  raw,
    output logic [RAW_W-1:0]  pack_out
);

    logic [NWORDS*WID_W-1:0] widths;
    assign widths = word_widths(slot);

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        logic [WID_W-1:0]  wid;
        logic [WORD_W-1:0] mask;
        assign wid  = widths[w*WID_W +: WID_W];
        assign mask = (wid >= WID_W'(WORD_W)) ? '1 : ((WORD_W'(1) << wid) - WORD_W'(1));
        assign pack_out[w*WORD_W +: WORD_W] = blank ? '0 : (raw[w*WORD_W +: WORD_W] & mask);
    end

endmodule

// File: rtl/ramdbg_reader.sv
module ramdbg_reader
    import ramdbg_pkg::*;
#(
    parameter int WAY_AB = 1,
    parameter int IDX_AB = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [31:0]  wr_data,
    input  logic [1:0]   wr_priv,
    input  logic         wr_ns,
    input  logic [1:0]   wr_core,
    input  logic [1:0]   own_core,
    input  logic         fill_en,
    input  logic [7:0]   fill_ram_id,
    input  logic [3:0]   fill_way,
    input  logic [17:0]  fill_index,
    input  logic         fill_valid,
    input  logic         fill_ns,
    input  logic [127:0] fill_data,
    output logic         busy,
    output logic         done,
    output logic         err,
    output logic [127:0] result
);

    localparam int ADDR_W = WAY_AB + IDX_AB;

    typedef enum logic [1:0] {S_IDLE, S_FETCH, S_COMMIT} state_e;

    state_e            state_q, state_d;
    ramsel_t           wsel, fsel;
    logic              accept, launch, reject;
    logic [SLOT_W-1:0] slot_q;
    grp_e              grp_q;
    logic              snoop_q, ns_q;
    logic [3:0]        way_q;
    logic [17:0]       idx_q;
    logic [1:0]        core_q;
    logic [ADDR_W-1:0] rd_addr, fill_addr;
    logic              rd_valid, rd_ns;
    logic [RAW_W-1:0]  rd_data, pack_out, result_q;
    logic              foreign, blank, done_q, err_q;
    logic              unused_bits;

    ramdbg_decode u_wdec (.ram_id(wr_data[31:24]), .sel(wsel));
    ramdbg_decode u_fdec (.ram_id(fill_ram_id),    .sel(fsel));

    assign fill_addr = {fill_way[WAY_AB-1:0], fill_index[IDX_AB-1:0]};
    assign rd_addr   = {way_q[WAY_AB-1:0], idx_q[IDX_AB-1:0]};

    ramdbg_array #(.ADDR_W(ADDR_W)) u_array (
        .clk      (clk),
        .wr_en    (fill_en && fsel.known),
        .wr_slot  (fsel.slot),
        .wr_addr  (fill_addr),
        .wr_valid (fill_valid),
        .wr_ns    (fill_ns),
        .wr_data  (fill_data),
        .rd_en    (state_q == S_FETCH),
        .rd_slot  (slot_q),
        .rd_addr  (rd_addr),
        .rd_valid (rd_valid),
        .rd_ns    (rd_ns),
        .rd_data  (rd_data)
    );

    // Ownership and security filter, evaluated while in COMMIT.
    assign foreign = (grp_q != GRP_L2_SHARED) &&
                     (snoop_q ? (idx_q[17:16] != core_q) : (core_q != own_core));
    assign blank   = foreign || (ns_q && !(rd_valid && rd_ns));

    ramdbg_pack u_pack (
        .slot     (slot_q),
        .blank    (blank),
        .raw      (rd_data),
        .pack_out (pack_out)
    );

    assign accept = wr_en && (state_q == S_IDLE);
    assign launch = accept && (wr_priv != 2'd0) && wsel.known;
    assign reject = accept && !launch;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (launch) state_d = S_FETCH;
            S_FETCH:  state_d = S_COMMIT;
            S_COMMIT: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // Capture, result and flag registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q   <= '0;
            grp_q    <= GRP_ISIDE;
            snoop_q  <= 1'b0;
            ns_q     <= 1'b0;
            way_q    <= '0;
            idx_q    <= '0;
            core_q   <= '0;
            result_q <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            done_q <= (state_q == S_COMMIT);
            if (reject) err_q <= 1'b1;
            if (launch) begin
                slot_q  <= wsel.slot;
                grp_q   <= wsel.grp;
                snoop_q <= wsel.snoop;
                way_q   <= wr_data[21:18];
                idx_q   <= wr_data[17:0];
                ns_q    <= wr_ns;
                core_q  <= wr_core;
            end
            if (state_q == S_COMMIT) result_q <= pack_out;
        end
    end

    assign busy   = (state_q != S_IDLE);
    assign done   = done_q;
    assign err    = err_q;
    assign result = result_q;

    assign unused_bits = ^{wr_data, fill_index, fill_way, fsel, way_q, idx_q};

    assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q) else $error("done held longer than one cycle");

    assert_commit_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_COMMIT) |=> done_q) else $error("COMMIT not followed by done");

    assert_busy_then_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> ($past(busy) && !busy)) else $error("done without preceding busy");

    assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done_q |-> $stable(result_q)) else $error("result changed without done");

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q) else $error("err cleared without reset");

endmodule

// File: tb/ramdbg_reader_test.sv
`timescale 1ns/1ps
module ramdbg_reader_test;

    localparam logic [1:0] OWN = 2'd1;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         wr_en, wr_ns, fill_en, fill_valid, fill_ns;
    logic [31:0]  wr_data;
    logic [1:0]   wr_priv, wr_core;
    logic [7:0]   fill_ram_id;
    logic [3:0]   fill_way;
    logic [17:0]  fill_index;
    logic [127:0] fill_data;
    logic         busy, done, err;
    logic [127:0] result;

    always #2.5 clk = ~clk;

    ramdbg_reader uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_priv(wr_priv),
        .wr_ns(wr_ns), .wr_core(wr_core), .own_core(OWN), .fill_en(fill_en),
        .fill_ram_id(fill_ram_id), .fill_way(fill_way), .fill_index(fill_index),
        .fill_valid(fill_valid), .fill_ns(fill_ns), .fill_data(fill_data),
        .busy(busy), .done(done), .err(err), .result(result)
    );

    typedef struct {
        logic [127:0] res;
        int           due;
        string        tag;
    } exp_t;

    exp_t         sbq[$];
    int           n_tests = 0;
    int           n_fail  = 0;
    int           cyc     = 0;
    logic [129:0] bmem [256][8];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic bit known_id(input logic [7:0] id);
        return (id <= 8'h05) || (id >= 8'h08 && id <= 8'h0B) || (id >= 8'h10 && id <= 8'h14) || (id == 8'h18);
    endfunction

    function automatic int kept(input logic [7:0] id, input int w);
        int t[4];
        case (id)
            8'h00, 8'h05: t = '{32, 0, 0, 0};
            8'h01:        t = '{32, 32, 8, 0};
            8'h02:        t = '{32, 32, 14, 0};
            8'h03:        t = '{32, 16, 0, 0};
            8'h04:        t = '{32, 32, 32, 0};
            8'h08, 8'h12: t = '{29, 7, 0, 0};
            8'h09:        t = '{32, 32, 7, 7};
            8'h0A, 8'h0B: t = '{32, 32, 32, 6};
            8'h10:        t = '{30, 7, 0, 0};
            8'h11:        t = '{32, 32, 32, 32};
            8'h13:        t = '{16, 0, 0, 0};
            8'h14:        t = '{18, 0, 0, 0};
            default:      t = '{32, 32, 32, 4};
        endcase
        return t[w];
    endfunction

    function automatic logic [127:0] expect_res(input logic [7:0] id, input logic [3:0] way,
                                                input logic [17:0] idx, input logic ns, input logic [1:0] core);
        logic [129:0] e;
        logic [127:0] r;
        bit           priv_arr, foreign;
        e        = bmem[id][{way[0], idx[1:0]}];
        priv_arr = (id <= 8'h0B) || (id == 8'h18);
        foreign  = (id == 8'h12) ? (idx[17:16] != core) : (priv_arr && core != OWN);
        if (foreign || (ns && !(e[129] && e[128]))) return '0;
        for (int w = 0; w < 4; w++) begin
            int           k;
            logic [31:0]  m;
            k = kept(id, w);
            m = (k >= 32) ? 32'hFFFF_FFFF : ((32'd1 << k) - 32'd1);
            r[w*32 +: 32] = e[w*32 +: 32] & m;
        end
        return r;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; wr_priv = '0; wr_ns = 1'b0; wr_core = '0;
        fill_en = 1'b0; fill_ram_id = '0; fill_way = '0; fill_index = '0;
        fill_valid = 1'b0; fill_ns = 1'b0; fill_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic fill(input logic [7:0] id, input logic [3:0] way, input logic [17:0] idx,
                        input logic v, input logic ns, input logic [127:0] d);
        @(negedge clk);
        fill_en = 1'b1; fill_ram_id = id; fill_way = way; fill_index = idx;
        fill_valid = v; fill_ns = ns; fill_data = d;
        bmem[id][{way[0], idx[1:0]}] = {v, ns, d};
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic issue(input logic [7:0] id, input logic [3:0] way, input logic [17:0] idx,
                         input logic [1:0] rsv, input logic [1:0] priv, input logic ns,
                         input logic [1:0] core, input string tag);
        logic [127:0] prev;
        bit           ok;
        exp_t         item;
        ok   = known_id(id) && (priv != 2'd0);
        prev = result;
        @(negedge clk);
        wr_en = 1'b1; wr_data = {id, rsv, way, idx}; wr_priv = priv; wr_ns = ns; wr_core = core;
        @(negedge clk);
        wr_en = 1'b0;
        if (ok) begin
            item.res = expect_res(id, way, idx, ns, core);
            item.due = cyc + 2;
            item.tag = tag;
            sbq.push_back(item);
        end
        repeat (3) @(negedge clk);
        if (ok) begin
            check("R3", "scoreboard drained", 128'(sbq.size()), 128'd0);
        end else begin
            check(tag, "err after rejected write", 128'(err), 128'd1);
            check(tag, "result unchanged", result, prev);
        end
    endtask

    // Monitor: pops expected items as done pulses appear
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sbq.size() == 0) begin
                n_tests++;
                n_fail++;
                $display("FAIL R4 unexpected done: actual 1 expected 0");
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check(e.tag, "result", result, e.res);
                check("R3", "done cycle", 128'(cyc), 128'(e.due));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] ids [16];
        ids = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h08, 8'h09,
                8'h0A, 8'h0B, 8'h10, 8'h11, 8'h12, 8'h13, 8'h14, 8'h18};
        do_reset();
        check("R12", "busy", 128'(busy), 128'd0);
        check("R12", "done", 128'(done), 128'd0);
        check("R12", "err", 128'(err), 128'd0);
        check("R12", "result", result, 128'd0);

        // R2: every identifier, secure owner read, full-ones and random contents
        foreach (ids[i]) begin
            fill(ids[i], 4'd1, {OWN, 16'h0002}, 1'b1, 1'b1, '1);
            issue(ids[i], 4'd1, {OWN, 16'h0002}, 2'b00, 2'd1, 1'b0, OWN, "R2");
            fill(ids[i], 4'd1, {OWN, 16'h0002}, 1'b1, 1'b1, {$urandom, $urandom, $urandom, $urandom});
            issue(ids[i], 4'd1, {OWN, 16'h0002}, 2'b00, 2'd2, 1'b0, OWN, "R2");
        end

        // R1: address formed from way bit 0 and index bits 1:0 only
        for (int a = 0; a < 8; a++) begin
            fill(8'h11, 4'(a >> 2), 18'(a & 3), 1'b1, 1'b0, {4{32'hC0DE_0000 | 32'(a)}});
        end
        issue(8'h11, 4'b1110, 18'h3_FFF1, 2'b11, 2'd1, 1'b0, 2'd3, "R1");
        issue(8'h11, 4'b0101, 18'h2_AAAA, 2'b10, 2'd3, 1'b0, OWN, "R1");
        issue(8'h11, 4'b0011, 18'h0_0003, 2'b01, 2'd1, 1'b0, OWN, "R1");

        // R8 / R9: security filter on data-side data array
        fill(8'h09, 4'd0, 18'd0, 1'b0, 1'b0, {$urandom, $urandom, $urandom, $urandom});
        issue(8'h09, 4'd0, 18'd0, 2'b00, 2'd1, 1'b0, OWN, "R8");
        issue(8'h09, 4'd0, 18'd0, 2'b00, 2'd1, 1'b1, OWN, "R9");
        fill(8'h09, 4'd0, 18'd1, 1'b1, 1'b0, '1);
        issue(8'h09, 4'd0, 18'd1, 2'b00, 2'd1, 1'b0, OWN, "R8");
        issue(8'h09, 4'd0, 18'd1, 2'b00, 2'd1, 1'b1, OWN, "R9");
        fill(8'h09, 4'd0, 18'd2, 1'b0, 1'b1, '1);
        issue(8'h09, 4'd0, 18'd2, 2'b00, 2'd1, 1'b1, OWN, "R9");
        fill(8'h09, 4'd0, 18'd3, 1'b1, 1'b1, {$urandom, $urandom, $urandom, $urandom});
        issue(8'h09, 4'd0, 18'd3, 2'b00, 2'd1, 1'b1, OWN, "R9");

        // R10: private arrays from a foreign core, shared L2 arrays from any core
        fill(8'h01, 4'd0, 18'd0, 1'b1, 1'b1, '1);
        issue(8'h01, 4'd0, 18'd0, 2'b00, 2'd1, 1'b0, 2'd2, "R10");
        fill(8'h18, 4'd1, 18'd1, 1'b1, 1'b1, '1);
        issue(8'h18, 4'd1, 18'd1, 2'b00, 2'd1, 1'b0, 2'd0, "R10");
        fill(8'h14, 4'd0, 18'd1, 1'b1, 1'b1, '1);
        issue(8'h14, 4'd0, 18'd1, 2'b00, 2'd1, 1'b0, 2'd3, "R10");
        issue(8'h11, 4'd1, 18'd2, 2'b00, 2'd1, 1'b1, 2'd0, "R10");

        // R11: snoop tag copy selected by index bits 17:16
        fill(8'h12, 4'd0, 18'd1, 1'b1, 1'b1, '1);
        issue(8'h12, 4'd0, {2'd3, 16'd1}, 2'b00, 2'd1, 1'b0, 2'd3, "R11");
        issue(8'h12, 4'd0, {2'd2, 16'd1}, 2'b00, 2'd1, 1'b0, 2'd3, "R11");
        issue(8'h12, 4'd0, {OWN, 16'd1}, 2'b00, 2'd1, 1'b0, 2'd0, "R11");

        // R4: write presented while busy is dropped
        begin
            exp_t item;
            @(negedge clk);
            wr_en = 1'b1; wr_data = {8'h14, 2'b00, 4'd0, 18'd1}; wr_priv = 2'd1; wr_ns = 1'b0; wr_core = OWN;
            @(negedge clk);
            item.res = expect_res(8'h14, 4'd0, 18'd1, 1'b0, OWN);
            item.due = cyc + 2;
            item.tag = "R4";
            sbq.push_back(item);
            check("R4", "busy after accept", 128'(busy), 128'd1);
            wr_data = {8'h11, 2'b00, 4'd0, 18'd0};
            @(negedge clk);
            check("R4", "busy in second cycle", 128'(busy), 128'd1);
            wr_en = 1'b0;
            repeat (5) @(negedge clk);
            check("R4", "busy after done", 128'(busy), 128'd0);
            check("R4", "scoreboard drained", 128'(sbq.size()), 128'd0);
        end

        // R6 then reset, R5, R7
        check("R6", "err before bad id", 128'(err), 128'd0);
        issue(8'h07, 4'd0, 18'd0, 2'b00, 2'd1, 1'b0, OWN, "R6");
        issue(8'h1F, 4'd0, 18'd0, 2'b00, 2'd3, 1'b0, OWN, "R6");
        do_reset();
        check("R7", "err cleared by reset", 128'(err), 128'd0);
        check("R12", "result after reset", result, 128'd0);
        issue(8'h11, 4'd1, 18'd2, 2'b00, 2'd1, 1'b0, OWN, "R7");
        issue(8'h11, 4'd1, 18'd3, 2'b00, 2'd0, 1'b0, OWN, "R5");
        issue(8'h11, 4'd0, 18'd1, 2'b00, 2'd1, 1'b0, OWN, "R7");
        check("R7", "err stays set after good read", 128'(err), 128'd1);

        repeat (4) @(negedge clk);
        check("R4", "no pending items at end", 128'(sbq.size()), 128'd0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule